// File: doc/BRIEF.md
# Bit-Serial Sign-Magnitude Multiply Element

This block is one multiply element of a neuron datapath. It receives an input sample one bit per clock and a weight as a parallel word. Both are 5-bit sign-magnitude values: a 4-bit magnitude with two integer and two fraction bits, plus a sign bit. The magnitudes are multiplied in a serial shift-add pipeline, and the product is cut down to its five most significant bits. The product sign is the exclusive-OR of the two operand signs.

The signed result leaves the block as a 6-bit two's complement word, least significant bit first, so that a serial adder can sum several elements directly. The sign-magnitude to two's complement conversion is done in the stream. Bits pass unchanged up to and including the first one. When the result is negative, every later bit is inverted.

Work is organised in 6-clock word frames, each marked by a start strobe. A frame's product leaves the block during the following frame.

Top module: `smul_top`

## Requirements
- R1: While rst_ni is low, and after reset until the first word produced by a frame, prod_o is 0.
- R2: start_i is high in the first cycle of every frame. x_i carries the magnitude in frame cycles 0 to 3, least significant bit first. It carries the sign (1 = negative) in cycle 4. Cycle 5 is a padding slot. Frames are exactly 6 cycles long and follow each other back to back.
- R3: The result magnitude is floor(|x| * |w| / 8), which is bits 7..3 of the 8-bit magnitude product. |x| and |w| are the 4-bit magnitude fields. w_i[3:0] is the weight magnitude.
- R4: The result sign is w_i[4] XOR the x sign bit. It appears as bit 5 of the output word.
- R5: A frame's 6-bit two's complement result is shifted out on prod_o least significant bit first. Bit 0 appears in the cycle after the next start_i and bit 5 five cycles later. After bit 5, prod_o keeps the sign bit until a new word is loaded.
- R6: A result whose truncated magnitude is zero is output as +0, all six bits 0, whatever the XOR of the signs.
- R7: w_i is sampled only in the start cycle. Changes on w_i during cycles 1 to 5 of a frame do not affect that frame's result.
- R8: The value on x_i in the padding cycle 5 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | First cycle of a word frame |
| x_i | input | 1 | Serial input sample: magnitude LSB first, then sign, then pad |
| w_i | input | 5 | Weight: bit 4 sign, bits 3..0 magnitude |
| prod_o | output | 1 | Serial two's complement product, LSB first |

## Verification
The assertions assume that start_i comes exactly every six cycles once the first frame has begun. They check this assumption as a frame-spacing property. Otherwise the output bit positions that the other properties rely on would not line up with a word. The stimulus therefore only drives whole 6-cycle frames back to back. It holds start_i low only before the first frame and after the last one, where the sign-extension hold of the final word is observed. Inside frames, the bench also exercises the two inputs the block must ignore: the padding slot is driven to 1, and w_i is inverted after the start cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned MAG_W_DEF = 4;

  function automatic int unsigned frame_len(input int unsigned mag_w);
    return mag_w + 2;
  endfunction
endpackage

// File: rtl/smul_mag_acc.sv
module smul_mag_acc #(
  parameter int unsigned MAG_W = smul_pkg::MAG_W_DEF,
  localparam int unsigned FRAME = smul_pkg::frame_len(MAG_W),
  localparam int unsigned PROD_W = 2 * MAG_W,
  localparam int unsigned TRUNC_W = MAG_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               x_i,
  input  logic [MAG_W:0]     w_i,
  output logic [TRUNC_W-1:0] mag_o,
  output logic               sgn_o
);
  localparam int unsigned CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] SGN_IDX  = CNT_W'(MAG_W);
  localparam logic [CNT_W-1:0] ONE_IDX  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PROD_W-1:0] acc_q;
  logic [MAG_W-1:0]  wmag_q;
  logic              wsgn_q, xsgn_q;

  // partial product for the current magnitude bit
  logic [PROD_W-1:0] pp;
  assign pp = x_i ? (PROD_W'(wmag_q) << cnt_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LAST_IDX;
      acc_q  <= '0;
      wmag_q <= '0;
      wsgn_q <= 1'b0;
      xsgn_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= ONE_IDX;
      acc_q  <= x_i ? PROD_W'(w_i[MAG_W-1:0]) : '0;
      wmag_q <= w_i[MAG_W-1:0];
      wsgn_q <= w_i[MAG_W];
    end else begin
      if (cnt_q != LAST_IDX) cnt_q <= cnt_q + ONE_IDX;
      if (cnt_q < SGN_IDX) acc_q <= acc_q + pp;
      else if (cnt_q == SGN_IDX) xsgn_q <= x_i;
    end
  end

  assign mag_o = acc_q[PROD_W-1 -: TRUNC_W];
  assign sgn_o = xsgn_q ^ wsgn_q;
endmodule

// File: rtl/smul_sm2tc.sv
module smul_sm2tc #(
  parameter int unsigned TRUNC_W = smul_pkg::MAG_W_DEF + 1,
  localparam int unsigned OUT_W = TRUNC_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [TRUNC_W-1:0] mag_i,
  input  logic               sgn_i,
  output logic               bit_o
);
  logic [OUT_W-1:0] sr_q;
  logic             neg_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      neg_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= {1'b0, mag_i};
      neg_q  <= sgn_i & (|mag_i); // zero magnitude stays +0
      seen_q <= 1'b0;
    end else begin
      sr_q   <= sr_q >> 1;
      seen_q <= seen_q | sr_q[0];
    end
  end

  // invert every bit after the first one when negative
  assign bit_o = sr_q[0] ^ (neg_q & seen_q);
endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int unsigned MAG_W = smul_pkg::MAG_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           x_i,
  input  logic [MAG_W:0] w_i,
  output logic           prod_o
);
  localparam int unsigned TRUNC_W = MAG_W + 1;

  logic [TRUNC_W-1:0] res_mag;
  logic               res_sgn;

  smul_mag_acc #(.MAG_W(MAG_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .x_i    (x_i),
    .w_i    (w_i),
    .mag_o  (res_mag),
    .sgn_o  (res_sgn)
  );

  smul_sm2tc #(.TRUNC_W(TRUNC_W)) u_conv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .mag_i (res_mag),
    .sgn_i (res_sgn),
    .bit_o (prod_o)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int unsigned MAG_W = smul_pkg::MAG_W_DEF,
  localparam int unsigned FRAME = smul_pkg::frame_len(MAG_W),
  localparam int unsigned TRUNC_W = MAG_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               prod_o,
  input logic [TRUNC_W-1:0] res_mag,
  input logic               res_sgn
);
  localparam int unsigned PW = $clog2(FRAME + 1);
  localparam logic [PW-1:0] P_END = PW'(FRAME);
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] pos_q;
  logic valid_q, nz_q, sgn_q, lsb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= P_END; valid_q <= 1'b0;
      nz_q <= 1'b0; sgn_q <= 1'b0; lsb_q <= 1'b0;
    end else if (start_i) begin
      pos_q <= P_ONE; valid_q <= 1'b1;
      nz_q <= |res_mag; sgn_q <= res_sgn; lsb_q <= res_mag[0];
    end else if (pos_q != P_END) begin
      pos_q <= pos_q + P_ONE;
    end
  end

  // R2
  frame_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && start_i) |-> pos_q == P_END);
  // R5
  first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && pos_q == P_ONE) |-> prod_o == lsb_q);
  // R4
  sign_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && nz_q && pos_q == P_END) |-> prod_o == sgn_q);
  // R6
  plus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !nz_q) |-> !prod_o);
endmodule

bind smul_top smul_chk #(.MAG_W(MAG_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .prod_o (prod_o),
  .res_mag(res_mag),
  .res_sgn(res_sgn)
);

// File: tb/sim_smul_top.sv
module sim_smul_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, start_i, x_i, prod_o;
  logic [4:0] w_i;

  smul_top u0 (.clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
               .x_i(x_i), .w_i(w_i), .prod_o(prod_o));

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    fill = 1'b0;
  string fill_tag = "R1";
  logic [4:0] prev_x = '0, prev_w = '0;
  string prev_tag = "R1";

  task automatic check(bit exp, string tag);
    checks++;
    if (prod_o !== exp) begin
      errors++;
      $display("FAIL %s: prod_o=%b expected %b at %0t", tag, prod_o, exp, $time);
    end
  endtask

  task automatic push_word(logic [4:0] x, logic [4:0] w, string tag);
    int p = (int'(x[3:0]) * int'(w[3:0])) / 8;
    bit sx = x[4] ^ w[4];
    int v = (sx && p != 0) ? -p : p;
    logic [5:0] b = v[5:0];
    string t = (sx && p == 0) ? "R6" : tag;
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back(b[i]);
      tag_q.push_back((i == 5 && t == "R3") ? "R4" : t);
    end
    fill = b[5];
    fill_tag = "R5";
  endtask

  task automatic step(bit s, bit xb, logic [4:0] w);
    start_i = s; x_i = xb; w_i = w;
    if (s) push_word(prev_x, prev_w, prev_tag);
    @(posedge clk);
    @(negedge clk);
    if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    else check(fill, fill_tag);
  endtask

  task automatic frame(logic [4:0] x, logic [4:0] w, bit pad, bit glitch, string tag);
    for (int i = 0; i < 6; i++) begin
      bit xb = (i < 5) ? x[i] : pad;
      logic [4:0] wv = (i == 0 || !glitch) ? w : ~w;
      step(i == 0, xb, wv);
    end
    prev_x = x; prev_w = w; prev_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; x_i = 1'b0; w_i = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(1'b0, "R1");
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0);

    frame(5'b0_0000, 5'b1_1111, 0, 0, "R6");
    frame(5'b0_0001, 5'b1_0001, 0, 0, "R6");
    frame(5'b0_1111, 5'b0_1111, 0, 0, "R3");
    frame(5'b1_1111, 5'b0_1111, 0, 0, "R4");
    frame(5'b1_1010, 5'b1_0110, 0, 0, "R4");
    frame(5'b0_1000, 5'b1_0011, 0, 0, "R4");
    frame(5'b1_0111, 5'b0_0101, 1, 0, "R8");
    frame(5'b0_1011, 5'b1_1101, 0, 1, "R7");
    frame(5'b0_0110, 5'b0_0111, 1, 1, "R7");
    frame(5'b1_0011, 5'b1_1100, 0, 0, "R2");
    frame(5'b0_1101, 5'b1_1001, 0, 0, "R2");

    for (int n = 0; n < 250; n++) begin
      logic [4:0] rx = 5'($urandom);
      logic [4:0] rw = 5'($urandom);
      bit pad = 1'($urandom);
      bit gl  = 1'($urandom);
      frame(rx, rw, pad, gl, gl ? "R7" : (pad ? "R8" : "R3"));
    end

    frame(5'b1_1110, 5'b0_1011, 0, 0, "R4");
    frame(5'b0_0000, 5'b0_0000, 0, 0, "R5");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule